// File: doc/BRIEF.md
# Three-of-Four Plane Coincidence Trigger

This block watches the hit-OR level outputs of four pixel tracking planes in one detector arm, all sampled on the bunch-crossing clock. It forms a 3-of-4 majority decision. When at least three enabled planes begin a hit at the same time, it sends one trigger pulse, exactly one crossing wide, toward the central trigger processor. Each hit-OR level stays high for roughly ten crossings. A veto stops that long level from producing repeat triggers. The output has a clean trailing edge because the receiver acts on the falling edge of the pulse.

Each input passes through a two-stage synchroniser. A plane fires in the crossing where its synchronised level rises. That fired state can be stretched by a programmable window of 0 to 3 extra crossings, which absorbs small skew between planes. After a trigger, a programmable dead time and a return of all enabled inputs to idle must both complete before the block can trigger again. A per-crossing coincidence flag is provided for monitoring. The block also keeps a running trigger count and records which planes formed the last accepted trigger.

Top module: `coinc_trig_top`

## Requirements
- R1: While rst_n is low and just after reset is released, trig_out and coinc_flag are 0, trig_count is 0 and last_pattern is 0.
- R2: A trigger is issued when at least three enabled planes are fired in the same crossing. Two fired planes never trigger.
- R3: trig_out is high for exactly one crossing. It goes high after the third rising clock edge that samples the last needed hit_in bit high, which is well inside the six-crossing budget.
- R4: A rising edge on a plane keeps it fired for its own crossing plus win_len further crossings (win_len 0 to 3). With win_len = 1, planes that are skewed by one crossing still coincide. With win_len = 0 they do not.
- R5: A plane whose plane_en bit is 0 never counts as fired. The threshold stays at three, so with one plane disabled all three remaining planes are needed.
- R6: After a trigger, no further trigger is issued until two things have happened: dead_len crossings have passed (a value of 0 acts as 1), and all enabled synchronised inputs are low with no coincidence window open. Long or repeated hits inside that span give one trigger.
- R7: trig_count increases by one for each issued trigger and wraps modulo 2^32.
- R8: last_pattern holds the enabled fired planes of the last trigger, with bit i standing for plane i (hit_in[i]).
- R9: A high cnt_clr on a clock edge sets trig_count and last_pattern to 0. It takes priority over a trigger on the same edge.
- R10: coinc_flag shows, one crossing later, whether three or more enabled planes were fired in each crossing. The veto does not affect it, and it is always high when trig_out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 4 | Raw hit-OR levels, bit i is plane i |
| plane_en | input | 4 | Per-plane enable mask |
| win_len | input | 2 | Extra crossings a plane stays fired after its edge |
| dead_len | input | 4 | Minimum veto length in crossings (0 acts as 1) |
| cnt_clr | input | 1 | Synchronous clear of trig_count and last_pattern |
| trig_out | output | 1 | One-crossing trigger pulse |
| coinc_flag | output | 1 | Per-crossing majority monitor flag |
| trig_count | output | 32 | Number of triggers issued |
| last_pattern | output | 4 | Enabled planes fired in the last trigger |

## Verification
The hardest situations to create are the ones where a second trigger is a real risk. One is re-arming after a short dead time while coincidence windows are still open. The other is a fresh edge arriving during the veto. The stimulus drives one-crossing pulses with the windows stretched and the dead time at both its shortest and longest settings. It also drives skewed edges whose spacing sits exactly at the window boundary. A behavioural model compares all outputs every crossing, so any extra or missing pulse shows up at once.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned PLANES_DEF = 4;
  localparam int unsigned THRESH_DEF = 3;
  localparam int unsigned WIN_W_DEF  = 2;
  localparam int unsigned DEAD_W_DEF = 4;
  localparam int unsigned CNT_W_DEF  = 32;
endpackage

// File: rtl/plane_front.sv
module plane_front #(
  parameter int unsigned WIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_raw,
  input  logic [WIN_W-1:0] win_len,
  output logic             sync_lvl,
  output logic             rise,
  output logic             fired
);
  logic s1_q, s2_q, s3_q;
  logic [WIN_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= hit_raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_lvl = s2_q;
  assign rise     = s2_q & ~s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (rise)           hold_q <= win_len;
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign fired = rise | (hold_q != '0);

  assert_window_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !rise) |-> $past(fired));
endmodule

// File: rtl/majority_vote.sv
module majority_vote #(
  parameter int unsigned N_PLANES = 4,
  parameter int unsigned THRESH   = 3
) (
  input  logic [N_PLANES-1:0] fired,
  input  logic [N_PLANES-1:0] plane_en,
  output logic [N_PLANES-1:0] voted,
  output logic                coinc
);
  function automatic int unsigned ones(input logic [N_PLANES-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < int'(N_PLANES); i++) n += int'(v[i]);
    return n;
  endfunction

  assign voted = fired & plane_en;
  assign coinc = ones(voted) >= THRESH;
endmodule

// File: rtl/trig_shaper.sv
module trig_shaper #(
  parameter int unsigned DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coinc,
  input  logic              quiet,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              fire,
  output logic              trig_out
);
  logic              armed_q;
  logic [DEAD_W-1:0] dead_q;

  function automatic logic [DEAD_W-1:0] dead_load(input logic [DEAD_W-1:0] len);
    return (len == '0) ? DEAD_W'(1) : len;
  endfunction

  assign fire = coinc & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      dead_q   <= '0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= fire;
      if (fire) begin
        armed_q <= 1'b0;
        dead_q  <= dead_load(dead_len);
      end else if (!armed_q) begin
        if (dead_q != '0) dead_q  <= dead_q - 1'b1;
        else if (quiet)   armed_q <= 1'b1;
      end
    end
  end

  assert_one_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> !fire);
endmodule

// File: rtl/coinc_trig_top.sv
module coinc_trig_top
  import trig_pkg::*;
#(
  parameter int unsigned N_PLANES = PLANES_DEF,
  parameter int unsigned THRESH   = THRESH_DEF,
  parameter int unsigned WIN_W    = WIN_W_DEF,
  parameter int unsigned DEAD_W   = DEAD_W_DEF,
  parameter int unsigned CNT_W    = CNT_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PLANES-1:0] hit_in,
  input  logic [N_PLANES-1:0] plane_en,
  input  logic [WIN_W-1:0]    win_len,
  input  logic [DEAD_W-1:0]   dead_len,
  input  logic                cnt_clr,
  output logic                trig_out,
  output logic                coinc_flag,
  output logic [CNT_W-1:0]    trig_count,
  output logic [N_PLANES-1:0] last_pattern
);
  logic [N_PLANES-1:0] sync_lvl, rise, fired, voted;
  logic coinc, quiet, fire;

  for (genvar g = 0; g < int'(N_PLANES); g++) begin : g_plane
    plane_front #(.WIN_W(WIN_W)) front_i (
      .clk(clk), .rst_n(rst_n), .hit_raw(hit_in[g]), .win_len(win_len),
      .sync_lvl(sync_lvl[g]), .rise(rise[g]), .fired(fired[g])
    );
  end

  majority_vote #(.N_PLANES(N_PLANES), .THRESH(THRESH)) vote_i (
    .fired(fired), .plane_en(plane_en), .voted(voted), .coinc(coinc)
  );

  assign quiet = ((sync_lvl & plane_en) == '0) && (voted == '0);

  trig_shaper #(.DEAD_W(DEAD_W)) shaper_i (
    .clk(clk), .rst_n(rst_n), .coinc(coinc), .quiet(quiet),
    .dead_len(dead_len), .fire(fire), .trig_out(trig_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coinc_flag   <= 1'b0;
      trig_count   <= '0;
      last_pattern <= '0;
    end else begin
      coinc_flag <= coinc;
      if (cnt_clr) begin
        trig_count   <= '0;
        last_pattern <= '0;
      end else if (fire) begin
        trig_count   <= trig_count + 1'b1;
        last_pattern <= voted;
      end
    end
  end

  assert_trig_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> coinc_flag);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cnt_clr) |=> trig_count == $past(trig_count) + 1'b1);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (trig_count == '0 && last_pattern == '0));
  assert_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !$past(cnt_clr)) |->
      ($countones(last_pattern) >= THRESH && (last_pattern & ~$past(plane_en)) == '0));
endmodule

// File: tb/coinc_trig_top_tb_top.sv
module coinc_trig_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] hit_in = '0, plane_en = 4'hF;
  logic [1:0] win_len = 2'd1;
  logic [3:0] dead_len = 4'd1;
  logic cnt_clr = 1'b0;
  logic trig_out, coinc_flag;
  logic [31:0] trig_count;
  logic [3:0] last_pattern;

  int checks = 0, failures = 0, cycles = 0, pulses = 0;

  always #10 clk = ~clk;

  coinc_trig_top dut_i (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .plane_en(plane_en),
    .win_len(win_len), .dead_len(dead_len), .cnt_clr(cnt_clr),
    .trig_out(trig_out), .coinc_flag(coinc_flag),
    .trig_count(trig_count), .last_pattern(last_pattern)
  );

  // behavioural reference model
  logic [3:0] hq[$];
  int hold[4];
  bit m_armed;
  int m_dead;
  logic m_trig, m_flag;
  logic [31:0] m_cnt;
  logic [3:0] m_pat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = {4'h0, 4'h0, 4'h0};
      foreach (hold[i]) hold[i] = 0;
      m_armed = 1; m_dead = 0; m_trig = 0; m_flag = 0; m_cnt = 0; m_pat = 0;
    end else begin
      logic [3:0] s2, s3, edge_v, fv, used;
      int n;
      bit cf, fr, qt;
      s2 = hq[1]; s3 = hq[2];
      edge_v = s2 & ~s3;
      for (int i = 0; i < 4; i++) fv[i] = edge_v[i] || (hold[i] > 0);
      used = fv & plane_en;
      n = 0;
      for (int i = 0; i < 4; i++) if (used[i]) n++;
      cf = (n >= 3);
      fr = cf && m_armed;
      qt = ((s2 & plane_en) == 0) && (used == 0);
      m_flag = cf;
      m_trig = fr;
      if (cnt_clr) begin m_cnt = 0; m_pat = 0; end
      else if (fr) begin m_cnt++; m_pat = used; end
      if (fr) begin m_armed = 0; m_dead = (dead_len == 0) ? 1 : int'(dead_len); end
      else if (!m_armed) begin
        if (m_dead > 0) m_dead--;
        else if (qt) m_armed = 1;
      end
      for (int i = 0; i < 4; i++)
        if (edge_v[i]) hold[i] = int'(win_len);
        else if (hold[i] > 0) hold[i]--;
      hq.push_front(hit_in);
      void'(hq.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (trig_out === 1'b1) pulses++;
    if (rst_n) begin
      chk("R3 trig_out model", 32'(trig_out), 32'(m_trig));
      chk("R10 coinc_flag model", 32'(coinc_flag), 32'(m_flag));
      chk("R7 trig_count model", trig_count, m_cnt);
      chk("R8 last_pattern model", 32'(last_pattern), 32'(m_pat));
    end
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] m, input int len);
    hit_in = m; idle(len); hit_in = '0;
  endtask

  initial begin
    logic [31:0] base;
    int p0;
    idle(3);
    chk("R1 reset trig_out", 32'(trig_out), 0);
    chk("R1 reset trig_count", trig_count, 0);
    chk("R1 reset last_pattern", 32'(last_pattern), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release coinc_flag", 32'(coinc_flag), 0);

    // R3 latency and width
    hit_in = 4'b0111;
    @(negedge clk); chk("R3 latency edge1", 32'(trig_out), 0);
    @(negedge clk); chk("R3 latency edge2", 32'(trig_out), 0);
    @(negedge clk); chk("R3 latency edge3", 32'(trig_out), 1);
    @(negedge clk); chk("R3 one wide", 32'(trig_out), 0);
    idle(7); hit_in = '0; idle(20);
    chk("R2 three planes count", trig_count, 1);
    chk("R8 pattern 0111", 32'(last_pattern), 32'h7);

    // R2 two planes only
    pulse(4'b1001, 10); idle(20);
    chk("R2 two planes no trigger", trig_count, 1);
    // four planes
    pulse(4'b1111, 10); idle(20);
    chk("R2 four planes", trig_count, 2);
    chk("R8 pattern 1111", 32'(last_pattern), 32'hF);

    // R4 skew with window 1
    hit_in = 4'b0011; idle(1); hit_in = 4'b1011; idle(10); hit_in = '0; idle(20);
    chk("R4 skew1 win1 triggers", trig_count, 3);
    chk("R8 pattern 1011", 32'(last_pattern), 32'hB);
    win_len = 2'd0;
    hit_in = 4'b0011; idle(1); hit_in = 4'b1011; idle(10); hit_in = '0; idle(20);
    chk("R4 skew1 win0 no trigger", trig_count, 3);
    win_len = 2'd1;
    hit_in = 4'b0001; idle(2); hit_in = 4'b0111; idle(10); hit_in = '0; idle(20);
    chk("R4 skew2 win1 no trigger", trig_count, 3);
    win_len = 2'd3;
    hit_in = 4'b0001; idle(3); hit_in = 4'b1101; idle(10); hit_in = '0; idle(20);
    chk("R4 skew3 win3 triggers", trig_count, 4);

    // R5 mask
    win_len = 2'd1; plane_en = 4'b1110;
    pulse(4'b0111, 10); idle(20);
    chk("R5 masked plane not counted", trig_count, 4);
    pulse(4'b1111, 10); idle(20);
    chk("R5 three enabled fire", trig_count, 5);
    chk("R5 pattern excludes masked", 32'(last_pattern), 32'hE);
    plane_en = 4'hF;

    // R6 long dead time against short repeated hits
    dead_len = 4'd15; win_len = 2'd3; base = trig_count; p0 = pulses;
    pulse(4'b0111, 1); idle(4); pulse(4'b1110, 1); idle(3); pulse(4'b1011, 1);
    idle(25);
    chk("R6 one trigger within dead time", trig_count, base + 1);
    chk("R6 single pulse count", 32'(pulses - p0), 1);
    pulse(4'b0111, 1); idle(25);
    chk("R6 rearmed after dead time", trig_count, base + 2);
    // R6 short dead time, long level held, windows open
    dead_len = 4'd0; p0 = pulses;
    pulse(4'b1111, 30); idle(20);
    chk("R6 long level one trigger", 32'(pulses - p0), 1);
    pulse(4'b0111, 1); idle(20);
    chk("R6 short pulse with windows one trigger", 32'(pulses - p0), 2);

    // R9 clear, also coincident with a trigger
    cnt_clr = 1'b1; idle(1); cnt_clr = 1'b0; idle(1);
    chk("R9 clear count", trig_count, 0);
    chk("R9 clear pattern", 32'(last_pattern), 0);
    hit_in = 4'b0111; idle(2); cnt_clr = 1'b1; idle(1); cnt_clr = 1'b0;
    chk("R9 clear beats trigger", trig_count, 0);
    idle(8); hit_in = '0; idle(20);
    pulse(4'b1110, 10); idle(20);
    chk("R7 count after clear", trig_count, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule